// File: doc/BRIEF.md
# Bus Initiator Phase Sequencer

This block is the control sequencer for the initiator side of a shared, multiplexed parallel bus that uses frame and ready handshakes with active-low signals. A local requester presents a transfer request together with a word count. The sequencer raises its bus request, waits for a grant on an idle bus, drives one address phase and then runs data phases. A word moves on each clock edge where the initiator ready, the target ready and the device select are all asserted.

The sequencer keeps FRAME# asserted until only one data phase is left. It holds its own ready line until the transfer completes or is cut short. It ends in one of three ways: all words moved, no target claimed the cycle in time (master abort), or the target asked it to stop. The last two report the number of words not moved, so the caller can retry them. Each shared control line gets one clock of deasserted drive before its output enable drops. The request line stays off for a minimum gap between two requests.

Datapath buffering, address and data muxing, configuration cycles, locked sequences and wide-path negotiation are handled outside this block.

Top module: `bus_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, req_n, frame_n and irdy_n are 1, frame_oe and irdy_oe are 0, and done, mabort and tstop are 0.
- R2: When xfer_req is sampled high in idle with a non-zero xfer_len, req_n goes to 0 after that clock edge. A request with xfer_len equal to 0 is ignored, and req_n stays 1.
- R3: While requesting, the address phase starts only at an edge where gnt_n is 0 and both frame_in_n and irdy_in_n are 1. frame_n goes to 0 after that edge, and irdy_n goes to 0 one clock later.
- R4: A word is counted on an edge only when irdy_n, trdy_n and devsel_n are all 0. Each counted word lowers remain_len by one.
- R5: frame_n returns to 1 at the edge that leaves one data phase outstanding, or at the end of the address phase when xfer_len is 1. At the edge that moves the last word, irdy_n returns to 1 and done is 1 for one clock, with remain_len 0.
- R6: Once irdy_n is 0, it stays 0 until the edge where done is raised.
- R7: If devsel_n is sampled 1 on each of the first CLAIM_WIN (default 5) edges after frame_n goes to 0, the cycle is master-aborted at that edge. frame_n goes to 1 first (when still 0), and irdy_n goes to 1 on the next edge together with done and mabort, with no words counted. A devsel_n sampled 0 on the last of those edges still claims the cycle.
- R8: When stop_n is sampled 0 in a data phase, a word moving on the same edge is still counted. If words then remain, frame_n goes to 1 (when still 0), then irdy_n goes to 1 together with done and tstop, and remain_len holds the uncounted words. If the stop edge moves the last word, the end is an ordinary completion with tstop 0.
- R9: Each of frame_n and irdy_n, when it returns to 1, stays driven (its output enable 1) for exactly one clock, and then its output enable goes to 0.
- R10: req_n returns to 1 on the edge that raises done, and stays 1 for at least REQ_GAP (default 2) clocks before it is driven to 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_req | input | 1 | Local request to start a transfer |
| xfer_len | input | LEN_W | Number of data words requested |
| gnt_n | input | 1 | Bus grant from the arbiter, active low |
| frame_in_n | input | 1 | FRAME# as sampled on the bus |
| irdy_in_n | input | 1 | IRDY# as sampled on the bus |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| req_n | output | 1 | Bus request to the arbiter, active low |
| frame_n | output | 1 | FRAME# drive value |
| frame_oe | output | 1 | Output enable for FRAME# |
| irdy_n | output | 1 | IRDY# drive value |
| irdy_oe | output | 1 | Output enable for IRDY# |
| done | output | 1 | One-clock pulse when a transaction ends |
| mabort | output | 1 | Qualifies done: master abort |
| tstop | output | 1 | Qualifies done: target stop with words left |
| remain_len | output | LEN_W | Words not yet moved in the current or last transfer |

## Verification
Two events can fall on the same edge: a target stop and a word transfer. The bench raises stop_n together with trdy_n while words remain. A correct result counts that word and reports the smaller remainder with tstop set. The bench also places the stop on the edge of the final word, where the expected result is an ordinary completion with tstop clear. A third case raises the stop with trdy_n held high, so nothing moves and the full remainder is reported. The claim window is probed at its last edge and one edge past it, to separate a late claim from a master abort.

// File: rtl/bis_pkg.sv
package bis_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADDR,
      ST_DATA,
      ST_WIND
   } bis_state_e;

   typedef enum logic [1:0] {
      END_OK,
      END_ABORT,
      END_STOP
   } bis_end_e;

endpackage

// File: rtl/bis_line_drv.sv
module bis_line_drv #(
   parameter int NLINE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NLINE-1:0] d_n,
   output logic [NLINE-1:0] q_n,
   output logic [NLINE-1:0] oe
);

   if (NLINE < 1) begin : g_bad_nline
      $error("bis_line_drv: NLINE must be at least 1");
   end

   for (genvar i = 0; i < NLINE; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_n[i] <= 1'b1;
            oe[i]  <= 1'b0;
         end else begin
            q_n[i] <= d_n[i];
            // keep driving for one clock after the line returns high
            oe[i]  <= ~d_n[i] | ~q_n[i];
         end
      end

      // R9: a line that returns high is still driven on that clock
      assert_high_driven_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(q_n[i]) |-> oe[i]);

      // R9: the enable drops only after one full clock of driven high
      assert_release_after_one_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(oe[i]) |-> (q_n[i] && $past(q_n[i])));
   end

endmodule

// File: rtl/bis_claim_timer.sv
module bis_claim_timer #(
   parameter int WIN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic armed,
   input  logic devsel_n,
   output logic expire
);

   localparam int CW = $clog2(WIN + 1);
   localparam logic [CW-1:0] LAST = CW'(WIN - 1);

   if (WIN < 2) begin : g_bad_win
      $error("bis_claim_timer: WIN must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          claimed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         claimed <= 1'b0;
      end else if (start) begin
         cnt     <= '0;
         claimed <= 1'b0;
      end else if (armed) begin
         if (!devsel_n) begin
            claimed <= 1'b1;
         end else if (!claimed && cnt != LAST) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign expire = armed && !claimed && devsel_n && (cnt == LAST);

   // checker: counts every armed edge since start, claim or not
   logic [CW-1:0] chk_edges;
   always_ff @(posedge clk) begin
      if (!rst_n)                       chk_edges <= '0;
      else if (start)                   chk_edges <= '0;
      else if (armed && chk_edges != LAST) chk_edges <= chk_edges + 1'b1;
   end

   // R7: expiry lands exactly on the last edge of the claim window
   assert_expire_window_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (chk_edges == LAST));

endmodule

// File: rtl/bis_beat_cnt.sv
module bis_beat_cnt #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             dec,
   output logic [LEN_W-1:0] rem,
   output logic             last,
   output logic             pen
);

   if (LEN_W < 2) begin : g_bad_len
      $error("bis_beat_cnt: LEN_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rem <= '0;
      else if (load) rem <= len;
      else if (dec)  rem <= rem - 1'b1;
   end

   assign last = (rem == LEN_W'(1));
   assign pen  = (rem == LEN_W'(2));

   // R4: a counted word never takes the count below zero
   assert_no_underflow_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (rem != '0));

   // R4: loading and counting never coincide
   assert_load_dec_excl_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(load && dec));

endmodule

// File: rtl/bis_req_gap.sv
module bis_req_gap #(
   parameter int GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n,
   output logic gap_ok
);

   localparam int GW = $clog2(GAP + 1);
   localparam logic [GW-1:0] OKV = GW'(GAP - 1);
   localparam logic [GW-1:0] SAT = GW'(GAP);

   if (GAP < 1) begin : g_bad_gap
      $error("bis_req_gap: GAP must be at least 1");
   end

   logic [GW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= OKV;
      else if (!req_n)       cnt <= '0;
      else if (cnt != OKV)   cnt <= cnt + 1'b1;
   end

   assign gap_ok = (cnt == OKV);

   // checker: length of the current run of high clocks on req_n
   logic [GW-1:0] hi_run;
   always_ff @(posedge clk) begin
      if (!rst_n)            hi_run <= SAT;
      else if (!req_n)       hi_run <= '0;
      else if (hi_run != SAT) hi_run <= hi_run + 1'b1;
   end

   // R10: a new request follows at least GAP high clocks
   assert_req_gap_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> (hi_run == SAT));

endmodule

// File: rtl/bus_init_seq.sv
module bus_init_seq
   import bis_pkg::*;
#(
   parameter int LEN_W     = 8,
   parameter int CLAIM_WIN = 5,
   parameter int REQ_GAP   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_req,
   input  logic [LEN_W-1:0] xfer_len,
   input  logic             gnt_n,
   input  logic             frame_in_n,
   input  logic             irdy_in_n,
   input  logic             devsel_n,
   input  logic             trdy_n,
   input  logic             stop_n,
   output logic             req_n,
   output logic             frame_n,
   output logic             frame_oe,
   output logic             irdy_n,
   output logic             irdy_oe,
   output logic             done,
   output logic             mabort,
   output logic             tstop,
   output logic [LEN_W-1:0] remain_len
);

   localparam int NLINE  = 2;
   localparam int L_FRM  = 0;
   localparam int L_IRDY = 1;

   bis_state_e st, st_d;
   bis_end_e   kind, kind_d;
   logic       req_d, done_d, mab_d, ts_d;
   logic       frame_d, irdy_d;
   logic [NLINE-1:0] line_d, line_q, line_oe;

   logic gap_ok, expire, rem_last, rem_pen;
   logic accept, go_addr, xfer, last_word, stop_hit, abort_hit;
   logic fin;
   bis_end_e fin_kind;

   assign frame_n  = line_q[L_FRM];
   assign irdy_n   = line_q[L_IRDY];
   assign frame_oe = line_oe[L_FRM];
   assign irdy_oe  = line_oe[L_IRDY];

   assign accept    = (st == ST_IDLE) && xfer_req && (xfer_len != '0) && gap_ok;
   assign go_addr   = (st == ST_REQ) && !gnt_n && frame_in_n && irdy_in_n;
   assign xfer      = (st == ST_DATA) && !irdy_n && !trdy_n && !devsel_n;
   assign last_word = xfer && rem_last;
   assign abort_hit = (st == ST_DATA) && expire;
   assign stop_hit  = (st == ST_DATA) && !stop_n && !last_word && !abort_hit;

   always_comb begin
      st_d     = st;
      kind_d   = kind;
      req_d    = req_n;
      frame_d  = frame_n;
      irdy_d   = irdy_n;
      fin      = 1'b0;
      fin_kind = END_OK;
      unique case (st)
         ST_IDLE: begin
            if (accept) begin
               req_d = 1'b0;
               st_d  = ST_REQ;
            end
         end
         ST_REQ: begin
            if (go_addr) begin
               frame_d = 1'b0;
               st_d    = ST_ADDR;
            end
         end
         ST_ADDR: begin
            irdy_d  = 1'b0;
            frame_d = rem_last;
            st_d    = ST_DATA;
         end
         ST_DATA: begin
            if (abort_hit || stop_hit) begin
               kind_d = abort_hit ? END_ABORT : END_STOP;
               if (!frame_n) begin
                  frame_d = 1'b1;
                  st_d    = ST_WIND;
               end else begin
                  fin      = 1'b1;
                  fin_kind = kind_d;
               end
            end else if (last_word) begin
               fin      = 1'b1;
               fin_kind = END_OK;
            end else if (xfer && rem_pen) begin
               frame_d = 1'b1;
            end
         end
         ST_WIND: begin
            fin      = 1'b1;
            fin_kind = kind;
         end
         default: st_d = ST_IDLE;
      endcase

      done_d = fin;
      mab_d  = fin && (fin_kind == END_ABORT);
      ts_d   = fin && (fin_kind == END_STOP);
      if (fin) begin
         irdy_d = 1'b1;
         req_d  = 1'b1;
         st_d   = ST_IDLE;
      end
   end

   assign line_d[L_FRM]  = frame_d;
   assign line_d[L_IRDY] = irdy_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         kind   <= END_OK;
         req_n  <= 1'b1;
         done   <= 1'b0;
         mabort <= 1'b0;
         tstop  <= 1'b0;
      end else begin
         st     <= st_d;
         kind   <= kind_d;
         req_n  <= req_d;
         done   <= done_d;
         mabort <= mab_d;
         tstop  <= ts_d;
      end
   end

   bis_line_drv #(.NLINE(NLINE)) u_lines (
      .clk   (clk),
      .rst_n (rst_n),
      .d_n   (line_d),
      .q_n   (line_q),
      .oe    (line_oe)
   );

   bis_claim_timer #(.WIN(CLAIM_WIN)) u_claim (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (go_addr),
      .armed    ((st == ST_ADDR) || (st == ST_DATA) || (st == ST_WIND)),
      .devsel_n (devsel_n),
      .expire   (expire)
   );

   bis_beat_cnt #(.LEN_W(LEN_W)) u_beats (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .len   (xfer_len),
      .dec   (xfer),
      .rem   (remain_len),
      .last  (rem_last),
      .pen   (rem_pen)
   );

   bis_req_gap #(.GAP(REQ_GAP)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_n  (req_n),
      .gap_ok (gap_ok)
   );

   // R3: FRAME# falls only after a granted, idle bus was sampled
   assert_addr_start_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n) |-> $past(!gnt_n && frame_in_n && irdy_in_n));

   // R3: IRDY# follows FRAME# by one clock
   assert_irdy_after_frame_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irdy_n) |-> (!frame_n || $past(!frame_n)));

   // R6: IRDY# is released only together with the end of the transaction
   assert_irdy_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irdy_n) |-> (done && frame_n));

   // R8: a stop report always carries a non-zero remainder
   assert_stop_remain_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      tstop |-> (done && remain_len != '0));

   // R5: an ordinary completion leaves nothing behind
   assert_clean_end_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mabort && !tstop) |-> (remain_len == '0));

   // R7: the two end qualifiers never appear together or without done
   assert_end_kind_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (mabort || tstop) |-> (done && !(mabort && tstop)));

   // R10: REQ# is released on the edge that ends the transaction
   assert_req_release_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n) |-> done);

endmodule

// File: tb/bus_init_seq_tb.sv
module bus_init_seq_tb;

   localparam int LEN_W = 8;
   localparam int NVEC  = 10;

   typedef struct packed {
      int len;   // words requested
      int dl;    // first edge (1-based after FRAME# edge) with DEVSEL# low
      int wt;    // wait clocks before each TRDY#
      int sat;   // words already moved when STOP# is raised (99 = never)
      int sx;    // 1: TRDY# low on the stop edge
      int erem;  // expected remain_len
      int emab;  // expected mabort
      int ets;   // expected tstop
      int ecyc;  // expected edge index of done, 0 = not checked
   } vec_t;

   localparam vec_t TAB [NVEC] = '{
      '{1, 1,  0, 99, 0, 0, 0, 0, 2},
      '{4, 2,  0, 99, 0, 0, 0, 0, 5},
      '{3, 3,  1, 99, 0, 0, 0, 0, 8},
      '{4, 5,  0, 99, 0, 0, 0, 0, 8},
      '{4, 99, 0, 99, 0, 4, 1, 0, 6},
      '{1, 99, 0, 99, 0, 1, 1, 0, 5},
      '{5, 1,  0, 2,  1, 2, 0, 1, 0},
      '{5, 1,  0, 2,  0, 3, 0, 1, 0},
      '{2, 1,  0, 1,  1, 0, 0, 0, 0},
      '{3, 1,  0, 0,  0, 3, 0, 1, 0}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             xfer_req;
   logic [LEN_W-1:0] xfer_len;
   logic             gnt_n, frame_in_n, irdy_in_n;
   logic             devsel_n, trdy_n, stop_n;
   logic             req_n, frame_n, frame_oe, irdy_n, irdy_oe;
   logic             done, mabort, tstop;
   logic [LEN_W-1:0] remain_len;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   bus_init_seq #(.LEN_W(LEN_W), .CLAIM_WIN(5), .REQ_GAP(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_len(xfer_len),
      .gnt_n(gnt_n), .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n),
      .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
      .req_n(req_n), .frame_n(frame_n), .frame_oe(frame_oe),
      .irdy_n(irdy_n), .irdy_oe(irdy_oe), .done(done), .mabort(mabort),
      .tstop(tstop), .remain_len(remain_len)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle_target();
      devsel_n = 1'b1;
      trdy_n   = 1'b1;
      stop_n   = 1'b1;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!done && n < 50) begin
         @(negedge clk);
         n++;
      end
      if (!done) chk({tag, " done reached"}, 0, 1);
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int  m = 0, words = 0, wcnt = 0, guard = 0;
      logic dev, stopped = 1'b0, prev_irdy = 1'b1, prev_trdy = 1'b1, prev_dev = 1'b0;
      logic irdy_seen = 1'b0, held_bad = 1'b0;
      string tg;
      tg = $sformatf("vec%0d", idx);
      xfer_len = LEN_W'(v.len);
      xfer_req = 1'b1;
      @(negedge clk);
      xfer_req = 1'b0;
      while (frame_n && guard < 20) begin
         @(negedge clk);
         guard++;
      end
      while (m < 60) begin
         if (!prev_irdy && !prev_trdy && prev_dev) begin
            words++;
            wcnt = 0;
         end
         if (done) break;
         if (irdy_seen && irdy_n) held_bad = 1'b1;
         if (!irdy_n) irdy_seen = 1'b1;
         dev = (m + 1 >= v.dl);
         if (stopped) begin
            stop_n = 1'b0;
            trdy_n = 1'b1;
         end else if (dev && words == v.sat) begin
            stop_n  = 1'b0;
            trdy_n  = (v.sx != 0) ? 1'b0 : 1'b1;
            stopped = 1'b1;
         end else if (dev) begin
            if (wcnt == v.wt) trdy_n = 1'b0;
            else begin
               trdy_n = 1'b1;
               wcnt++;
            end
         end else begin
            trdy_n = 1'b1;
         end
         devsel_n  = !dev;
         prev_irdy = irdy_n;
         prev_trdy = trdy_n;
         prev_dev  = dev;
         @(negedge clk);
         m++;
      end
      chk({tg, " R5 done seen"}, int'(done), 1);
      chk({tg, " R4 R8 remain_len"}, int'(remain_len), v.erem);
      chk({tg, " R4 words moved"}, words, v.len - v.erem);
      chk({tg, " R7 mabort"}, int'(mabort), v.emab);
      chk({tg, " R8 tstop"}, int'(tstop), v.ets);
      chk({tg, " R6 irdy held"}, int'(held_bad), 0);
      chk({tg, " R5 lines high at end"}, int'(frame_n && irdy_n), 1);
      if (v.ecyc != 0) chk({tg, " R7 R5 end edge"}, m, v.ecyc);
      idle_target();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; xfer_req = 1'b0; xfer_len = '0;
      gnt_n = 1'b0; frame_in_n = 1'b1; irdy_in_n = 1'b1;
      idle_target();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 req_n in reset", int'(req_n), 1);
      chk("R1 lines in reset", int'({frame_n, irdy_n, frame_oe, irdy_oe}), 4'b1100);
      chk("R1 status in reset", int'({done, mabort, tstop}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", int'({req_n, frame_n, irdy_n, frame_oe, irdy_oe, done}), 6'b111000);

      // table of transactions
      for (int i = 0; i < NVEC; i++) run_vec(TAB[i], i);

      // R2: zero length is ignored
      xfer_len = '0;
      xfer_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 zero length ignored", int'(req_n), 1);
      xfer_req = 1'b0;

      // R2, R3: grant and idle-bus gating
      gnt_n = 1'b1;
      xfer_len = LEN_W'(1);
      xfer_req = 1'b1;
      @(negedge clk);
      xfer_req = 1'b0;
      chk("R2 req_n one clock after request", int'(req_n), 0);
      repeat (3) @(negedge clk);
      chk("R3 no start without grant", int'(frame_n), 1);
      gnt_n = 1'b0;
      frame_in_n = 1'b0;
      @(negedge clk);
      chk("R3 no start on busy bus", int'(frame_n), 1);
      frame_in_n = 1'b1;
      irdy_in_n = 1'b0;
      @(negedge clk);
      chk("R3 no start while bus IRDY# low", int'(frame_n), 1);
      irdy_in_n = 1'b1;
      @(negedge clk);
      chk("R3 start after idle bus", int'(frame_n), 0);
      // R9: release sequence of a one-word transfer
      chk("R9 frame driven at start", int'({frame_oe, irdy_n}), 2'b11);
      devsel_n = 1'b0;
      trdy_n   = 1'b0;
      @(negedge clk);
      chk("R3 R5 irdy low, frame high", int'({frame_n, irdy_n}), 2'b10);
      chk("R9 frame still driven high", int'({frame_oe, irdy_oe}), 2'b11);
      @(negedge clk);
      chk("R9 frame released", int'(frame_oe), 0);
      chk("R5 done with irdy high", int'({done, irdy_n, irdy_oe}), 3'b111);
      @(negedge clk);
      chk("R9 irdy released", int'({irdy_oe, done}), 0);
      idle_target();
      repeat (3) @(negedge clk);

      // R10: back-to-back requests observe the request gap
      devsel_n = 1'b0;
      trdy_n   = 1'b0;
      xfer_len = LEN_W'(1);
      xfer_req = 1'b1;
      @(negedge clk);
      wait_done("R10 first");
      chk("R10 req_n high at done", int'(req_n), 1);
      @(negedge clk);
      chk("R10 req_n high one clock later", int'(req_n), 1);
      @(negedge clk);
      chk("R10 req_n low after gap", int'(req_n), 0);
      xfer_req = 1'b0;
      @(negedge clk);
      wait_done("R10 second");
      chk("R10 second ends cleanly", int'({mabort, tstop, remain_len}), 0);
      idle_target();
      repeat (3) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule